// File: doc/BRIEF.md
# Shadowed PHY Register Bank

This block sits behind a single register address of a PHY's management port and fronts eight shadow registers through it. Each 16-bit write carries two 3-bit selectors. The low selector names the shadow that the write targets. The upper selector names the shadow that later reads return. A write-enable flag in the top bit of the word decides what the write does. When the flag is set, the write stores its payload bits into the targeted shadow. When the flag is clear, the write only moves the selectors. A read never names its own target; it always shows the shadow chosen by the last write.

The port is a plain synchronous register port, not a stream. A write strobe that is already address-matched commits on the clock edge where it is high. The port has no ready signal and never applies back-pressure, so every strobed word is taken in that cycle. Read data is combinational from the latched read selector. The bank also decodes the misc-control shadow (code 7) into individual configuration pins that drive the rest of the PHY. Shadow codes 3 and 6 are reserved slots with no storage.

Top module: `shadow_reg_bank`

## Requirements
- R1: After a synchronous active-low reset, the read selector is 000 and every shadow payload is zero, except misc-control bit 5, which is 1. So `rd_data` reads 16'h0000 and `oob_status_dis` is 1.
- R2: Every strobed write loads the read selector from `wr_data[14:12]`, whatever the value of `wr_data[15]`. The selector keeps that value until the next strobed write.
- R3: A strobed write with `wr_data[15]`=1 stores `wr_data[11:3]` into the payload of the shadow named by `wr_data[2:0]`, subject to R5 and R6.
- R4: A strobed write with `wr_data[15]`=0 leaves every shadow payload unchanged.
- R5: Shadow codes 011 and 110 hold nothing. Writes that target them store nothing, and while either is the read selector, `rd_data[11:3]` is zero.
- R6: In the misc-control shadow (code 111), bits 10 and 4 are not stored and always read as 0.
- R7: `rd_data[15]` is always 0. `rd_data[14:12]` and `rd_data[2:0]` both equal the current read selector. `rd_data[11:3]` is the payload of the selected shadow.
- R8: The misc-control outputs follow the stored misc-control bits as follows: bit 11 → `pkt_cnt_rx`, bit 9 → `force_mdix`, bit 8 → `rx_clk_delay`, bit 7 → `rgmii_en`, bit 6 → `rxer_mode`, bit 5 → `oob_status_dis`, bit 3 → `all_phy_wr`.
- R9: While `wr_en` is low, neither the read selector nor any payload changes, whatever `wr_data` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Address-matched write strobe |
| wr_data | input | 16 | Write word: enable flag, read selector, payload, write selector |
| rd_data | output | 16 | Read word for the selected shadow |
| pkt_cnt_rx | output | 1 | Packet counter source: 1 receive, 0 transmit |
| force_mdix | output | 1 | Crossover detection kept on while auto-negotiation is off |
| rx_clk_delay | output | 1 | 1 delayed receive-clock timing, 0 aligned |
| rgmii_en | output | 1 | Reduced-pin gigabit MAC interface enable |
| rxer_mode | output | 1 | Receive-error signalling mode |
| oob_status_dis | output | 1 | 1 sends ordinary data in the inter-packet gap instead of status |
| all_phy_wr | output | 1 | Writes to PHY address 0 reach all PHYs |

## Verification
Directed sequences first check the reset state. They then check that a selector-only write moves the read view and leaves stored data alone, which separates R2 from R4. Writes with all ones to the reserved codes and to the masked misc bits show that the reserved slots and bit positions stay empty, and reads there return zero in the payload field. Random words follow, with the enable flag, the write target and the read target drawn independently. Because the write target and the read target are drawn separately, a design that reads the write target, or that stores into the read target, is told apart from a correct one. The misc-control pins are compared on every cycle, and idle cycles with noise on the data bus show that the strobe gates all updates.

// File: rtl/shadow_bank_pkg.sv
package shadow_bank_pkg;
  localparam int DATA_W    = 16;
  localparam int SEL_W     = 3;
  localparam int NUM_SLOTS = 1 << SEL_W;
  localparam int WSEL_LSB  = 0;
  localparam int PAY_LSB   = WSEL_LSB + SEL_W;
  localparam int RSEL_LSB  = 12;
  localparam int PAY_W     = RSEL_LSB - PAY_LSB;
  localparam int WE_BIT    = DATA_W - 1;

  localparam int SLOT_MISC  = 7;
  localparam int SLOT_RSV_A = 3;
  localparam int SLOT_RSV_B = 6;

  typedef logic [PAY_W-1:0] payload_t;
  typedef logic [SEL_W-1:0] sel_t;

  // misc-control field positions, counted from the payload LSB
  localparam int MC_PKT_RX  = 11 - PAY_LSB;
  localparam int MC_MDIX    = 9 - PAY_LSB;
  localparam int MC_RXCLK   = 8 - PAY_LSB;
  localparam int MC_RGMII   = 7 - PAY_LSB;
  localparam int MC_RXER    = 6 - PAY_LSB;
  localparam int MC_OOB_DIS = 5 - PAY_LSB;
  localparam int MC_ALL_PHY = 3 - PAY_LSB;

  typedef struct packed {
    logic pkt_rx;
    logic mdix;
    logic rx_clk_delay;
    logic rgmii;
    logic rxer;
    logic oob_dis;
    logic all_phy;
  } misc_fields_t;

  function automatic logic slot_is_reserved(input int s);
    return (s == SLOT_RSV_A) || (s == SLOT_RSV_B);
  endfunction

  function automatic payload_t slot_wmask(input int s);
    payload_t m;
    if (slot_is_reserved(s)) begin
      m = '0;
    end else if (s == SLOT_MISC) begin
      m = '0;
      m[MC_PKT_RX]  = 1'b1;
      m[MC_MDIX]    = 1'b1;
      m[MC_RXCLK]   = 1'b1;
      m[MC_RGMII]   = 1'b1;
      m[MC_RXER]    = 1'b1;
      m[MC_OOB_DIS] = 1'b1;
      m[MC_ALL_PHY] = 1'b1;
    end else begin
      m = '1;
    end
    return m;
  endfunction

  function automatic payload_t slot_rst_val(input int s);
    payload_t v;
    v = '0;
    if (s == SLOT_MISC) v[MC_OOB_DIS] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/shadow_wr_decode.sv
module shadow_wr_decode
  import shadow_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NUM_SLOTS-1:0] slot_we,
  output payload_t          wr_payload,
  output sel_t              rd_sel
);
  sel_t wsel;
  logic full_wr;

  assign wsel       = wr_data[WSEL_LSB +: SEL_W];
  assign wr_payload = wr_data[PAY_LSB +: PAY_W];
  assign full_wr    = wr_en & wr_data[WE_BIT];

  always_comb begin
    slot_we = '0;
    if (full_wr) slot_we[wsel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_sel <= '0;
    end else if (wr_en) begin
      rd_sel <= wr_data[RSEL_LSB +: SEL_W];
    end
  end
endmodule

// File: rtl/shadow_slot.sv
module shadow_slot
  import shadow_bank_pkg::*;
#(
  parameter payload_t WMASK    = '1,
  parameter payload_t RST_VAL  = '0,
  parameter bit       RESERVED = 1'b0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     we,
  input  payload_t wdata,
  output payload_t q
);
  generate
    if (RESERVED) begin : g_empty
      assign q = '0;
    end else begin : g_store
      payload_t store_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          store_q <= RST_VAL & WMASK;
        end else if (we) begin
          store_q <= wdata & WMASK;
        end
      end
      assign q = store_q;
    end
  endgenerate
endmodule

// File: rtl/shadow_rd_mux.sv
module shadow_rd_mux
  import shadow_bank_pkg::*;
(
  input  payload_t          slot_q [NUM_SLOTS],
  input  sel_t              rd_sel,
  output logic [DATA_W-1:0] rd_data
);
  always_comb begin
    rd_data = '0;
    rd_data[RSEL_LSB +: SEL_W] = rd_sel;
    rd_data[PAY_LSB  +: PAY_W] = slot_q[rd_sel];
    rd_data[WSEL_LSB +: SEL_W] = rd_sel;
  end
endmodule

// File: rtl/shadow_reg_bank.sv
module shadow_reg_bank
  import shadow_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              pkt_cnt_rx,
  output logic              force_mdix,
  output logic              rx_clk_delay,
  output logic              rgmii_en,
  output logic              rxer_mode,
  output logic              oob_status_dis,
  output logic              all_phy_wr
);
  logic [NUM_SLOTS-1:0] slot_we;
  payload_t             wr_payload;
  sel_t                 rd_sel;
  payload_t             slot_q [NUM_SLOTS];
  misc_fields_t         misc;

  shadow_wr_decode u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .slot_we    (slot_we),
    .wr_payload (wr_payload),
    .rd_sel     (rd_sel)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    shadow_slot #(
      .WMASK    (slot_wmask(s)),
      .RST_VAL  (slot_rst_val(s)),
      .RESERVED (slot_is_reserved(s))
    ) u_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (slot_we[s]),
      .wdata (wr_payload),
      .q     (slot_q[s])
    );
  end

  shadow_rd_mux u_mux (
    .slot_q  (slot_q),
    .rd_sel  (rd_sel),
    .rd_data (rd_data)
  );

  always_comb begin
    misc.pkt_rx       = slot_q[SLOT_MISC][MC_PKT_RX];
    misc.mdix         = slot_q[SLOT_MISC][MC_MDIX];
    misc.rx_clk_delay = slot_q[SLOT_MISC][MC_RXCLK];
    misc.rgmii        = slot_q[SLOT_MISC][MC_RGMII];
    misc.rxer         = slot_q[SLOT_MISC][MC_RXER];
    misc.oob_dis      = slot_q[SLOT_MISC][MC_OOB_DIS];
    misc.all_phy      = slot_q[SLOT_MISC][MC_ALL_PHY];
  end

  assign pkt_cnt_rx     = misc.pkt_rx;
  assign force_mdix     = misc.mdix;
  assign rx_clk_delay   = misc.rx_clk_delay;
  assign rgmii_en       = misc.rgmii;
  assign rxer_mode      = misc.rxer;
  assign oob_status_dis = misc.oob_dis;
  assign all_phy_wr     = misc.all_phy;
endmodule

// File: rtl/shadow_reg_bank_chk.sv
module shadow_reg_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic [15:0] rd_data,
  input logic        pkt_cnt_rx,
  input logic        force_mdix,
  input logic        rx_clk_delay,
  input logic        rgmii_en,
  input logic        rxer_mode,
  input logic        oob_status_dis,
  input logic        all_phy_wr
);
  logic [6:0] mc;
  assign mc = {pkt_cnt_rx, force_mdix, rx_clk_delay, rgmii_en,
               rxer_mode, oob_status_dis, all_phy_wr};

  assert_rsel_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[14:12] == $past(wr_data[14:12]));

  assert_rsel_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data));

  assert_misc_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[15] && wr_data[2:0] == 3'd7) |=>
      mc == $past({wr_data[11], wr_data[9], wr_data[8], wr_data[7],
                   wr_data[6], wr_data[5], wr_data[3]}));

  assert_selonly_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[15]) |=> $stable(mc));

  assert_rsv_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[14:12] == 3'd3 || rd_data[14:12] == 3'd6) |-> rd_data[11:3] == 9'd0);

  assert_misc_rsv_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[14:12] == 3'd7) |-> (rd_data[10] == 1'b0 && rd_data[4] == 1'b0));

  assert_word_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[15] == 1'b0 && rd_data[14:12] == rd_data[2:0]);

  assert_misc_view_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[14:12] == 3'd7) |->
      mc == {rd_data[11], rd_data[9], rd_data[8], rd_data[7],
             rd_data[6], rd_data[5], rd_data[3]});
endmodule

bind shadow_reg_bank shadow_reg_bank_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .wr_en          (wr_en),
  .wr_data        (wr_data),
  .rd_data        (rd_data),
  .pkt_cnt_rx     (pkt_cnt_rx),
  .force_mdix     (force_mdix),
  .rx_clk_delay   (rx_clk_delay),
  .rgmii_en       (rgmii_en),
  .rxer_mode      (rxer_mode),
  .oob_status_dis (oob_status_dis),
  .all_phy_wr     (all_phy_wr)
);

// File: tb/shadow_reg_bank_tb_top.sv
module shadow_reg_bank_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic pkt_cnt_rx, force_mdix, rx_clk_delay, rgmii_en, rxer_mode, oob_status_dis, all_phy_wr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [8:0] mdl_pay [8];
  logic [2:0] mdl_rsel;

  always #(CLK_PERIOD/2) clk = ~clk;

  shadow_reg_bank dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .pkt_cnt_rx(pkt_cnt_rx), .force_mdix(force_mdix), .rx_clk_delay(rx_clk_delay),
    .rgmii_en(rgmii_en), .rxer_mode(rxer_mode), .oob_status_dis(oob_status_dis),
    .all_phy_wr(all_phy_wr)
  );

  function automatic logic [8:0] mask_for(input int s);
    if (s == 3 || s == 6) return 9'h000;
    if (s == 7) return 9'b1_0111_1101;
    return 9'h1FF;
  endfunction

  function automatic logic [15:0] exp_word();
    return {1'b0, mdl_rsel, mdl_pay[mdl_rsel], mdl_rsel};
  endfunction

  function automatic logic [6:0] exp_misc();
    logic [15:0] w;
    w = {4'b0, mdl_pay[7], 3'b0};
    return {w[11], w[9], w[8], w[7], w[6], w[5], w[3]};
  endfunction

  task automatic mdl_reset();
    for (int s = 0; s < 8; s++) mdl_pay[s] = 9'h000;
    mdl_pay[7] = 9'h004;
    mdl_rsel = 3'd0;
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check(req, rd_data, exp_word());
    check({req, "/R8"}, {9'b0, pkt_cnt_rx, force_mdix, rx_clk_delay, rgmii_en,
                         rxer_mode, oob_status_dis, all_phy_wr},
          {9'b0, exp_misc()});
  endtask

  task automatic do_write(input logic [15:0] w, input string req);
    @(negedge clk);
    wr_en = 1'b1; wr_data = w;
    @(negedge clk);
    wr_en = 1'b0; wr_data = $urandom();
    mdl_rsel = w[14:12];
    if (w[15]) mdl_pay[w[2:0]] = w[11:3] & mask_for(int'(w[2:0]));
    check_all(req);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
    mdl_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset");
    check("R1 oob reset", {15'b0, oob_status_dis}, 16'h0001);

    // R3: full write to misc, read it back
    do_write(16'hFFFF, "R3 misc all ones");
    // R6: bits 10 and 4 dropped
    check("R6 misc masked", rd_data, 16'h7BEF);
    // R4: selector-only write with ones payload to slot 1, view slot 7
    do_write(16'h7001 | 16'h0FF8, "R4 selonly");
    do_write(16'h9AA9, "R3 slot1 store");
    do_write(16'h1000, "R4 view slot1 kept");
    // R5: reserved codes
    do_write(16'hBFFB, "R5 write rsv3 view rsv3");
    check("R5 rsv read", rd_data, 16'h3003);
    do_write(16'hEFFE, "R5 write rsv6 view rsv6");
    do_write(16'h4004, "R2 view slot4");
    // R9: noise with strobe low
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      wr_data = $urandom();
      check_all("R9 idle");
    end
    // R7 + random mix
    for (int i = 0; i < 400; i++) begin
      logic [15:0] w;
      w = $urandom();
      if ((i % 5) == 0) w[2:0] = 3'd7;
      do_write(w, "R7 random");
      check("R7 bit15 zero", {15'b0, rd_data[15]}, 16'h0);
    end
    // reset mid-run returns to reset state
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    mdl_reset();
    check_all("R1 re-reset");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule